// File: doc/BRIEF.md
# Serial converter command and result port

This block is the digital serial front end of a two-input, 12-bit sampling converter, seen from the converter's side. A host lowers chip select and clocks a short command into the serial data input. Leading zeros are skipped. The first one is taken as a start marker, and the four bits after it choose the input multiplexer arrangement, a power-down request and the order in which the result is returned. The block drives the multiplexer code and pulses a sample strobe to the converter core. It then shifts the parallel 12-bit result out on the serial data output, one bit per falling serial clock edge.

The result can be sent most-significant bit first only, or most-significant bit first followed by an 11-bit least-significant-first repeat. A power-down request sends twelve ones instead of a result and raises a shutdown flag. That flag holds until chip select falls again. Raising chip select ends any transfer at once and turns the output driver off.

All logic runs on one system clock. Chip select, serial clock and data input are sampled on that clock, so the serial clock edges are detected as events. The serial clock must stay in each level for at least two system clocks.

Top module: `sadc_port`

## Requirements
- R1: After reset, the output enable `dout_oe` is 0, `dout` is 0, `mux_cfg` is 2'b00, `sample` is 0 and `shutdown` is 0.
- R2: With chip select low, data input bits are taken on serial clock rising edges. Zeros before the first one are ignored. The first one is the start marker. The next four bits are, in order: single-ended flag S, odd flag O, power bit P (0 means power down) and order bit M (1 means MSB-first only).
- R3: A command with P=1 sets `mux_cfg` to {~S, O}. The codes are: 00 is input 0 against ground, 01 is input 1 against ground, 10 is input 0 positive and input 1 negative, 11 is input 1 positive and input 0 negative. A command with P=0 leaves `mux_cfg` unchanged.
- R4: `dout_oe` is 0 while chip select is high and while the command is being received. On the serial clock falling edge after the rising edge that takes M, `dout_oe` becomes 1 and `dout` carries a single 0. After that, `dout` changes only on serial clock falling edges.
- R5: With M=1, the twelve result bits follow the leading 0, bit 11 first. After them `dout` stays 0 for as long as the clock runs.
- R6: With M=0, the MSB-first result is followed by result bits 1 through 11, in that order. `dout` then stays 0.
- R7: With P=0, `shutdown` goes to 1, `dout` sends twelve ones after the leading 0 and then zeros, and no `sample` pulse occurs.
- R8: `shutdown` stays 1 after chip select rises and clears when chip select next falls. A conversion command in that same frame is served normally.
- R9: Chip select going high at any point drops `dout_oe` and returns the parser to looking for a start marker. This holds in the middle of a command and in the middle of the output.
- R10: Each conversion command (P=1) gives exactly one `sample` pulse, one system clock long.
- R11: Data input values after the fourth command bit have no effect on `dout` or on the other outputs until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| result | input | 12 | Conversion result from the converter core |
| dout | output | 1 | Serial data out (0 when not enabled) |
| dout_oe | output | 1 | Enable for the tri-state pad driving serial data out |
| mux_cfg | output | 2 | Analog multiplexer code |
| sample | output | 1 | One-clock strobe that starts a conversion |
| shutdown | output | 1 | Power-down flag for the analog section |

## Verification
The bench sends leading runs of zero to seven zeros. A parser that missed the start marker, or took it too early, would shift the mux code and scramble the result order. The 11-bit repeat is compared bit by bit against results whose LSB and MSB differ. This catches a design that sends bit 0 twice or leaves out bit 11. Ones are held on the data input throughout the output phase, so a parser that did not lock after four bits would restart and misplace the stream. Two further tests check aborts: one in the middle of a command and one in the middle of the output. Another test covers a shutdown followed directly by a conversion. These catch a parser left half-loaded, a driver left enabled, and a shutdown flag that clears too early or too late.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_CMD  = 2'd1,
    PH_DONE = 2'd2
  } parse_st_t;

  // first received command bit lands in the most significant field
  typedef struct packed {
    logic sgl;
    logic odd;
    logic pwr;
    logic msb_only;
  } cmd_t;

endpackage

// File: rtl/sadc_edges.sv
module sadc_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall
);

  logic sclk_q, sclk_n;
  logic cs_q, cs_n_nxt;

  always_comb begin
    sclk_n   = sclk;
    cs_n_nxt = cs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_n;
      cs_q   <= cs_n_nxt;
    end
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign sclk_fall = ~sclk & sclk_q;
  assign cs_fall   = ~cs_n & cs_q;

endmodule

// File: rtl/sadc_parser.sv
module sadc_parser
  import sadc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk_rise,
  input  logic din,
  output cmd_t cmd,
  output logic cmd_ready,
  output logic cmd_strobe
);

  localparam int CMD_BITS = $bits(cmd_t);
  localparam int CNT_W    = $clog2(CMD_BITS);

  parse_st_t            st_q, st_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [CMD_BITS-1:0]  sh_q, sh_n;
  logic                 stb_q, stb_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    sh_n  = sh_q;
    stb_n = 1'b0;
    if (cs_n) begin
      st_n  = PH_HUNT;
      cnt_n = '0;
    end else if (sclk_rise) begin
      case (st_q)
        PH_HUNT: begin
          if (din) begin
            st_n  = PH_CMD;
            cnt_n = '0;
          end
        end
        PH_CMD: begin
          sh_n = {sh_q[CMD_BITS-2:0], din};
          if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
            st_n  = PH_DONE;
            stb_n = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_HUNT;
      cnt_q <= '0;
      sh_q  <= '0;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
      stb_q <= stb_n;
    end
  end

  assign cmd        = cmd_t'(sh_q);
  assign cmd_ready  = (st_q == PH_DONE);
  assign cmd_strobe = stb_q;

  // R9: a high chip select always sends the parser back to hunting
  a_r9_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st_q == PH_HUNT));

  // R11: once done, the command fields stay frozen while chip select is low
  a_r11_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_DONE) && !cs_n |=> $stable(sh_q));

endmodule

// File: rtl/sadc_seq.sv
module sadc_seq #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk_fall,
  input  logic             cmd_ready,
  input  logic             pwr,
  input  logic             msb_only,
  input  logic [RES_W-1:0] result,
  output logic             dout_bit,
  output logic             dout_oe
);

  localparam int POS_MAX = 2 * RES_W - 1;
  localparam int POS_W   = $clog2(POS_MAX + 1);

  logic             oe_q, oe_n;
  logic             bit_q, bit_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [RES_W-1:0] res_q, res_n;
  logic             stream_bit;

  // bit chosen for the current output position
  always_comb begin
    stream_bit = 1'b0;
    if (!pwr) begin
      stream_bit = (int'(pos_q) < RES_W);
    end else if (int'(pos_q) < RES_W) begin
      for (int k = 0; k < RES_W; k++)
        if (k == RES_W - 1 - int'(pos_q)) stream_bit = res_q[k];
    end else if (!msb_only && int'(pos_q) < POS_MAX) begin
      for (int k = 1; k < RES_W; k++)
        if (k == int'(pos_q) - RES_W + 1) stream_bit = res_q[k];
    end
  end

  always_comb begin
    oe_n  = oe_q;
    bit_n = bit_q;
    pos_n = pos_q;
    res_n = res_q;
    if (cs_n) begin
      oe_n  = 1'b0;
      bit_n = 1'b0;
      pos_n = '0;
    end else if (sclk_fall) begin
      if (!oe_q && cmd_ready) begin
        oe_n  = 1'b1;
        bit_n = 1'b0;
        pos_n = '0;
        res_n = result;
      end else if (oe_q) begin
        bit_n = stream_bit;
        pos_n = (pos_q == POS_W'(POS_MAX)) ? pos_q : pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      bit_q <= 1'b0;
      pos_q <= '0;
      res_q <= '0;
    end else begin
      oe_q  <= oe_n;
      bit_q <= bit_n;
      pos_q <= pos_n;
      res_q <= res_n;
    end
  end

  assign dout_bit = bit_q;
  assign dout_oe  = oe_q;

  // R4: driver turns off after chip select goes high
  a_r4_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !oe_q);

  // R4: driver turns on only once a full command is held
  a_r4_on_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(cmd_ready));

  // R4: output bit moves only on a serial clock falling edge (or deselect)
  a_r4_bit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_q) |-> ($past(sclk_fall) || $past(cs_n)));

  // R6: position never runs past the end of the repeat
  a_r6_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_q) <= POS_MAX);

endmodule

// File: rtl/sadc_port.sv
module sadc_port
  import sadc_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic [RES_W-1:0] result,
  output logic             dout,
  output logic             dout_oe,
  output logic [1:0]       mux_cfg,
  output logic             sample,
  output logic             shutdown
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       sclk_rise, sclk_fall, cs_fall;
  cmd_t       cmd;
  logic       cmd_ready, cmd_strobe;
  logic       dbit, oe;
  logic [1:0] mux_q, mux_n;
  logic       shd_q, shd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sadc_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_fall   (cs_fall)
  );

  sadc_parser u_parser (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cs_n       (cs_n),
    .sclk_rise  (sclk_rise),
    .din        (din),
    .cmd        (cmd),
    .cmd_ready  (cmd_ready),
    .cmd_strobe (cmd_strobe)
  );

  sadc_seq #(.RES_W(RES_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_n      (cs_n),
    .sclk_fall (sclk_fall),
    .cmd_ready (cmd_ready),
    .pwr       (cmd.pwr),
    .msb_only  (cmd.msb_only),
    .result    (result),
    .dout_bit  (dbit),
    .dout_oe   (oe)
  );

  always_comb begin
    mux_n = mux_q;
    shd_n = shd_q;
    if (cmd_strobe && cmd.pwr) mux_n = {~cmd.sgl, cmd.odd};
    if (cmd_strobe && !cmd.pwr) shd_n = 1'b1;
    else if (cs_fall)           shd_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mux_q <= 2'b00;
      shd_q <= 1'b0;
    end else begin
      mux_q <= mux_n;
      shd_q <= shd_n;
    end
  end

  assign sample   = cmd_strobe & cmd.pwr;
  assign mux_cfg  = mux_q;
  assign shutdown = shd_q;
  assign dout_oe  = oe;
  assign dout     = oe & dbit;

  // R8: a new frame clears power-down
  a_r8_clear_on_select: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cs_fall |=> !shd_q);

  // R7: no conversion strobe while powered down
  a_r7_no_sample_in_shutdown: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sample |-> !shd_q);

  // R10: strobe is a single cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sample |=> !sample);

  // R3: mux code moves only on a conversion command
  a_r3_mux_on_convert: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(mux_q) |-> $past(sample));

endmodule

// File: tb/tb_sadc_port.sv
module tb_sadc_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] result = 12'h000;
  logic        dout, dout_oe, sample, shutdown;
  logic [1:0]  mux_cfg;

  int n_chk = 0;
  int n_bad = 0;
  int n_samp = 0;
  logic [1:0] exp_mux = 2'b00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sadc_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .result(result), .dout(dout), .dout_oe(dout_oe), .mux_cfg(mux_cfg),
    .sample(sample), .shutdown(shutdown)
  );

  always @(negedge clk) if (sample) n_samp++;

  // fields: lead[18:16] S O P M [15:12] result[11:0]
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 4'b1011, 12'hA5C},
    {3'd3, 4'b1110, 12'h3C1},
    {3'd1, 4'b0011, 12'hFFF},
    {3'd5, 4'b0110, 12'h001},
    {3'd2, 4'b1001, 12'h5A5},
    {3'd7, 4'b0110, 12'h800},
    {3'd0, 4'b1100, 12'h123},
    {3'd4, 4'b0010, 12'hBEE}
  };

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic ref_bit(input int p, input logic [11:0] r,
                                   input logic pw, input logic m);
    if (!pw) return (p < 12);
    if (p < 12) return r[11-p];
    if (!m && p < 23) return r[p-11];
    return 1'b0;
  endfunction

  // one serial bit: drive din while low, sample output, then pulse sclk high
  task automatic bit_cycle(input logic d, output logic got, output logic got_oe);
    @(negedge clk) din = d;
    repeat (3) @(negedge clk);
    got = dout;
    got_oe = dout_oe;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_cmd(input int lead, input logic [3:0] c, input string tag);
    logic g, go;
    for (int i = 0; i < lead; i++) begin
      bit_cycle(1'b0, g, go);
      check(!go, {tag, " R4 lead hi-z"}, go, 0);
    end
    bit_cycle(1'b1, g, go);
    check(!go, {tag, " R2 start hi-z"}, go, 0);
    for (int i = 3; i >= 0; i--) begin
      bit_cycle(c[i], g, go);
      check(!go, {tag, " R4 cmd hi-z"}, go, 0);
    end
  endtask

  task automatic read_out(input int n, input logic [11:0] r, input logic pw,
                          input logic m, input string tag);
    logic g, go;
    for (int j = 0; j < n; j++) begin
      bit_cycle(1'b1, g, go);   // R11: ones on din during output
      if (j == 0) begin
        check(go && g == 1'b0, {tag, " R4 null bit"}, {go, g}, 2);
      end else begin
        logic e;
        e = ref_bit(j - 1, r, pw, m);
        check(go && g == e,
              {tag, pw ? (m ? " R5 msb stream" : " R6 repeat stream") : " R7 ones stream",
               " R11"}, {go, g}, {1'b1, e});
      end
    end
  endtask

  task automatic deselect(input string tag);
    @(negedge clk) cs_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!dout_oe && !dout, {tag, " R9 off after deselect"}, {dout_oe, dout}, 0);
  endtask

  task automatic frame(input int lead, input logic [3:0] c, input logic [11:0] r,
                       input string tag);
    int s0;
    result = r;
    s0 = n_samp;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    send_cmd(lead, c, tag);
    read_out(27, r, c[1], c[0], tag);
    if (c[1]) exp_mux = {~c[3], c[2]};
    check(mux_cfg == exp_mux, {tag, " R3 mux code"}, mux_cfg, exp_mux);
    check(n_samp - s0 == (c[1] ? 1 : 0), {tag, " R10 sample count"}, n_samp - s0, c[1] ? 1 : 0);
    check(shutdown == !c[1], {tag, " R7 shutdown flag"}, shutdown, !c[1]);
    deselect(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic g, go;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!dout_oe && !dout, "R1 output off", {dout_oe, dout}, 0);
    check(mux_cfg == 2'b00, "R1 mux", mux_cfg, 0);
    check(!sample && !shutdown, "R1 strobe/flag", {sample, shutdown}, 0);

    for (int v = 0; v < 8; v++) begin
      frame(int'(VEC[v][18:16]), VEC[v][15:12], VEC[v][11:0], $sformatf("vec%0d", v));
    end

    // R8: shutdown holds across deselect, clears on next select, conversion follows
    frame(1, 4'b1101, 12'h0F0, "shd");
    check(shutdown == 1'b1, "R8 held while deselected", shutdown, 1);
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    check(shutdown == 1'b0, "R8 cleared on select", shutdown, 0);
    result = 12'h6B2;
    send_cmd(0, 4'b0111, "R8 wake");
    read_out(14, 12'h6B2, 1'b1, 1'b1, "R8 wake");
    exp_mux = 2'b11;
    check(mux_cfg == exp_mux, "R8 wake R3 mux", mux_cfg, exp_mux);
    deselect("R8 wake");

    // R9: abort during command
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    bit_cycle(1'b1, g, go);
    bit_cycle(1'b0, g, go);
    bit_cycle(1'b1, g, go);
    deselect("R9 mid-cmd");
    frame(2, 4'b1011, 12'hC3A, "R9 after cmd abort");

    // R9: abort during output
    result = 12'hF0F;
    @(negedge clk) cs_n = 1'b0;
    repeat (2) @(negedge clk);
    send_cmd(0, 4'b1111, "R9 mid-out");
    read_out(5, 12'hF0F, 1'b1, 1'b1, "R9 mid-out");
    deselect("R9 mid-out");
    frame(0, 4'b0010, 12'h7E1, "R9 after out abort");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule